// File: doc/BRIEF.md
# Serial Transmit Clock Selector

This block picks and conditions the bit clock for a synchronous serial transmitter. Three candidate clocks arrive as slow signals: a divided system clock, the clock of the receive side, and the level seen on a bidirectional clock pin. A 6-bit mode register chooses one of them as the internal transmit clock. The same register decides whether the block drives the clock pin, either all the time or only while a transfer is in progress. A third field of the register picks which edge of the internal clock shifts data out and which edge samples an incoming frame sync.

The selected source is sampled by the fast system clock through a synchronizer. Its edges become one-cycle strobes: a shift strobe for the transmit shifter and a frame-sync sample strobe for the frame logic. The pin output is a registered copy of the synchronized clock. It is gated for transfer-only operation, and the gate is allowed to switch only while the clock is low. A write-protect input freezes the mode register. A guard stops the block from driving the pin when the pin is also the chosen source.

Top module: `txclk_select`

## Requirements
- R1: While reset is asserted and on leaving it, both strobes, `pinClkOut` and `pinClkOe` are 0, and `modeRd` reads 0.
- R2: Mode bits 1:0 choose the source: 0 is `divClk`, 1 is `rxClk`, 2 is `pinClkIn`, and the reserved code 3 acts as 0.
- R3: Mode bits 4:2 set the pin role: 0 leaves the pin undriven (`pinClkOe` 0, `pinClkOut` 0), 1 drives continuously, 2 drives during transfers only, and the reserved codes 3 to 7 act as 0.
- R4: With mode bit 5 at 0, `shiftStb` marks each falling edge of the selected source and `fsSampleStb` marks each rising edge. A strobe is high in the cycle that follows the second system-clock edge after the first edge that captures the new level.
- R5: With mode bit 5 at 1, the two strobes trade edges: `shiftStb` marks rising edges and `fsSampleStb` marks falling edges.
- R6: When the pin is driven, `pinClkOut` follows the synchronized source with the same polarity whatever bit 5 holds. It rises or falls one cycle after the matching strobe would.
- R7: While `wpLock` is 1, a write on `cfgWrEn` leaves the mode register (and `modeRd`) unchanged. While `wpLock` is 0, the write takes effect at the next clock edge.
- R8: If source code 2 (pin) is combined with pin code 1 or 2, then `pinClkOe` is 0 and `pinClkOut` stays 0.
- R9: In transfer-only mode, `pinClkOut` stays low while `xferActive` is low. The gate changes only while the synchronized clock is low, so every high phase on the pin is whole.
- R10: Each strobe is one system-clock cycle wide, and the two strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfgWrEn | input | 1 | Mode register write strobe |
| cfgWrData | input | 6 | Mode register write value |
| wpLock | input | 1 | Write-protect enable; blocks mode writes when 1 |
| modeRd | output | 6 | Current mode register contents |
| divClk | input | 1 | Divided system clock source |
| rxClk | input | 1 | Receive-side clock source |
| pinClkIn | input | 1 | Level on the clock pin |
| xferActive | input | 1 | High while a transfer is in progress |
| shiftStb | output | 1 | One-cycle strobe on the data-shift edge |
| fsSampleStb | output | 1 | One-cycle strobe on the frame-sync sample edge |
| pinClkOut | output | 1 | Value to drive on the clock pin |
| pinClkOe | output | 1 | Output enable for the clock pin |

## Verification
The embedded properties assume that the selected source holds each level for at least two system-clock cycles. They also assume that mode writes are spaced apart, so that a source change or a polarity swap cannot create a one-cycle pulse. The stimulus meets both assumptions: the three clocks toggle every four, six and five system cycles, and every write is followed by a long run of idle cycles. `xferActive` is toggled at times unrelated to the selected clock. This lets the gate hold rule meet requests that arrive both in high phases and in low phases.

// File: rtl/txclk_pkg.sv
package txclk_pkg;

  localparam int MODE_W   = 6;
  localparam int SRC_LSB  = 0;
  localparam int SRC_W    = 2;
  localparam int PIN_LSB  = 2;
  localparam int PIN_W    = 3;
  localparam int INV_BIT  = 5;

  typedef enum logic [1:0] {
    SRC_DIV = 2'd0,
    SRC_RX  = 2'd1,
    SRC_PIN = 2'd2
  } srcSel_e;

  localparam logic [PIN_W-1:0] PIN_CODE_CONT = 3'd1;
  localparam logic [PIN_W-1:0] PIN_CODE_XFER = 3'd2;

  // decoded controls handed from the control half to the datapath half
  typedef struct packed {
    srcSel_e srcSel;
    logic    invert;
    logic    pinDrive;
    logic    xferOnly;
  } clkCtl_t;

endpackage

// File: rtl/txclk_ctrl.sv
module txclk_ctrl
  import txclk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgWrEn,
  input  logic [MODE_W-1:0] cfgWrData,
  input  logic              wpLock,
  output logic [MODE_W-1:0] modeQ,
  output clkCtl_t           ctl,
  output logic              pinOe
);

  logic [SRC_W-1:0] srcCode;
  logic [PIN_W-1:0] pinCode;
  srcSel_e          srcDec;
  logic             wantDrive;
  logic             loopHazard;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modeQ <= '0;
    end else if (cfgWrEn && !wpLock) begin
      modeQ <= cfgWrData;
    end
  end

  assign srcCode = modeQ[SRC_LSB +: SRC_W];
  assign pinCode = modeQ[PIN_LSB +: PIN_W];

  always_comb begin
    case (srcCode)
      2'd1:    srcDec = SRC_RX;
      2'd2:    srcDec = SRC_PIN;
      default: srcDec = SRC_DIV;
    endcase
  end

  assign wantDrive  = (pinCode == PIN_CODE_CONT) || (pinCode == PIN_CODE_XFER);
  assign loopHazard = (srcDec == SRC_PIN) && wantDrive;
  assign pinOe      = wantDrive && !loopHazard;

  always_comb begin
    ctl          = '0;
    ctl.srcSel   = srcDec;
    ctl.invert   = modeQ[INV_BIT];
    ctl.pinDrive = pinOe;
    ctl.xferOnly = (pinCode == PIN_CODE_XFER);
  end

  AST_WP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    wpLock |=> $stable(modeQ)); // R7

  AST_NO_PIN_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
    (modeQ[SRC_LSB +: SRC_W] == 2'd2) |-> !pinOe); // R8

endmodule

// File: rtl/txclk_dp.sv
module txclk_dp
  import txclk_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  clkCtl_t ctl,
  input  logic    divClk,
  input  logic    rxClk,
  input  logic    pinClkIn,
  input  logic    xferActive,
  output logic    shiftStb,
  output logic    fsSampleStb,
  output logic    pinClkOut
);

  localparam int CHAIN_W = SYNC_STAGES + 1;

  logic               srcRaw;
  logic [CHAIN_W-1:0] syncQ;
  logic               srcNow;
  logic               srcPrev;
  logic               riseStb;
  logic               fallStb;
  logic               gateQ;
  logic               gateWant;
  logic               pinQ;

  always_comb begin
    case (ctl.srcSel)
      SRC_RX:  srcRaw = rxClk;
      SRC_PIN: srcRaw = pinClkIn;
      default: srcRaw = divClk;
    endcase
  end

  // synchronizer plus one history stage for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncQ <= '0;
    end else begin
      syncQ <= {syncQ[CHAIN_W-2:0], srcRaw};
    end
  end

  assign srcNow  = syncQ[SYNC_STAGES-1];
  assign srcPrev = syncQ[SYNC_STAGES];
  assign riseStb = srcNow && !srcPrev;
  assign fallStb = !srcNow && srcPrev;

  assign shiftStb    = ctl.invert ? riseStb : fallStb;
  assign fsSampleStb = ctl.invert ? fallStb : riseStb;

  // pin gate: only allowed to move while the synchronized clock is low
  assign gateWant = ctl.pinDrive && (!ctl.xferOnly || xferActive);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gateQ <= 1'b0;
      pinQ  <= 1'b0;
    end else begin
      if (!srcNow) begin
        gateQ <= gateWant;
      end
      pinQ <= ctl.pinDrive && gateQ && srcNow;
    end
  end

  assign pinClkOut = pinQ;

  AST_GATE_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (srcNow && $past(srcNow)) |-> $stable(gateQ)); // R9

  AST_SHIFT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    shiftStb |=> !shiftStb); // R10

  AST_SAMPLE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    fsSampleStb |=> !fsSampleStb); // R10

  AST_UNDRIVEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.pinDrive |=> !pinClkOut); // R3

endmodule

// File: rtl/txclk_select.sv
module txclk_select
  import txclk_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgWrEn,
  input  logic [MODE_W-1:0] cfgWrData,
  input  logic              wpLock,
  output logic [MODE_W-1:0] modeRd,
  input  logic              divClk,
  input  logic              rxClk,
  input  logic              pinClkIn,
  input  logic              xferActive,
  output logic              shiftStb,
  output logic              fsSampleStb,
  output logic              pinClkOut,
  output logic              pinClkOe
);

  clkCtl_t ctl;

  txclk_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfgWrEn   (cfgWrEn),
    .cfgWrData (cfgWrData),
    .wpLock    (wpLock),
    .modeQ     (modeRd),
    .ctl       (ctl),
    .pinOe     (pinClkOe)
  );

  txclk_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl         (ctl),
    .divClk      (divClk),
    .rxClk       (rxClk),
    .pinClkIn    (pinClkIn),
    .xferActive  (xferActive),
    .shiftStb    (shiftStb),
    .fsSampleStb (fsSampleStb),
    .pinClkOut   (pinClkOut)
  );

endmodule

// File: tb/txclk_select_bench.sv
`timescale 1ns/1ps
module txclk_select_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfgWrEn = 1'b0;
  logic [5:0] cfgWrData = '0;
  logic       wpLock = 1'b0;
  logic [5:0] modeRd;
  logic       divClk = 1'b0;
  logic       rxClk = 1'b0;
  logic       pinClkIn = 1'b0;
  logic       xferActive = 1'b0;
  logic       shiftStb, fsSampleStb, pinClkOut, pinClkOe;

  int vecCnt = 0;
  int failCnt = 0;
  int cyc = 0;
  bit done = 1'b0;
  string curReq = "R1";

  always #10 clk = ~clk;  // 50 MHz

  txclk_select u_txclk_select (
    .clk(clk), .rst_n(rst_n), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .wpLock(wpLock), .modeRd(modeRd), .divClk(divClk), .rxClk(rxClk),
    .pinClkIn(pinClkIn), .xferActive(xferActive), .shiftStb(shiftStb),
    .fsSampleStb(fsSampleStb), .pinClkOut(pinClkOut), .pinClkOe(pinClkOe)
  );

  // ---------------- reference model ----------------
  bit       hist[$];
  bit [5:0] modeM;
  bit       gateM, pinM;

  function automatic int srcOf(bit [5:0] m);
    if (m[1:0] == 2'd1) return 1;
    if (m[1:0] == 2'd2) return 2;
    return 0;
  endfunction

  function automatic bit oeOf(bit [5:0] m);
    bit drive;
    drive = (m[4:2] == 3'd1) || (m[4:2] == 3'd2);
    return drive && (srcOf(m) != 2);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist.delete();
      repeat (3) hist.push_back(1'b0);
      modeM = '0; gateM = 1'b0; pinM = 1'b0;
    end else begin
      bit raw, s2old, newPin;
      int sidx;
      sidx  = srcOf(modeM);
      raw   = (sidx == 1) ? rxClk : (sidx == 2) ? pinClkIn : divClk;
      s2old = hist[hist.size()-2];
      newPin = oeOf(modeM) && gateM && s2old;
      if (!s2old) gateM = oeOf(modeM) && ((modeM[4:2] != 3'd2) || xferActive);
      pinM = newPin;
      hist.push_back(raw);
      if (hist.size() > 8) void'(hist.pop_front());
      if (cfgWrEn && !wpLock) modeM = cfgWrData;
    end
  end

  // ---------------- compare ----------------
  bit prevShift = 1'b0, prevSample = 1'b0;

  task automatic compare();
    bit s2, s3, rise, fall, eShift, eSample;
    s2 = hist[hist.size()-2];
    s3 = hist[hist.size()-3];
    rise = s2 && !s3;
    fall = !s2 && s3;
    eShift  = modeM[5] ? rise : fall;
    eSample = modeM[5] ? fall : rise;
    vecCnt++;
    if (shiftStb !== eShift || fsSampleStb !== eSample || pinClkOut !== pinM ||
        pinClkOe !== oeOf(modeM) || modeRd !== modeM) begin
      failCnt++;
      $display("FAIL %s cyc %0d: shift=%b/%b sample=%b/%b pin=%b/%b oe=%b/%b mode=%h/%h (actual/expected)",
               curReq, cyc, shiftStb, eShift, fsSampleStb, eSample, pinClkOut, pinM,
               pinClkOe, oeOf(modeM), modeRd, modeM);
    end
    // R10: one-cycle strobes, never together
    vecCnt++;
    if ((shiftStb && fsSampleStb) || (shiftStb && prevShift) || (fsSampleStb && prevSample)) begin
      failCnt++;
      $display("FAIL R10 cyc %0d: shift=%b sample=%b prevShift=%b prevSample=%b expected single exclusive pulses",
               cyc, shiftStb, fsSampleStb, prevShift, prevSample);
    end
    prevShift  = shiftStb;
    prevSample = fsSampleStb;
  endtask

  task automatic tick();
    @(negedge clk);
    compare();
    cyc++;
    divClk   = ((cyc / 4) % 2) != 0;
    rxClk    = ((cyc / 6) % 2) != 0;
    pinClkIn = ((cyc / 5) % 2) != 0;
  endtask

  task automatic run(int n);
    repeat (n) tick();
  endtask

  task automatic writeMode(bit [5:0] v);
    cfgWrEn = 1'b1; cfgWrData = v;
    tick();
    cfgWrEn = 1'b0;
  endtask

  // ---------------- stimulus ----------------
  initial begin
    repeat (3) @(negedge clk);
    curReq = "R1";
    vecCnt++;
    if (shiftStb !== 1'b0 || fsSampleStb !== 1'b0 || pinClkOut !== 1'b0 ||
        pinClkOe !== 1'b0 || modeRd !== 6'h00) begin
      failCnt++;
      $display("FAIL R1 reset: shift=%b sample=%b pin=%b oe=%b mode=%h expected all 0",
               shiftStb, fsSampleStb, pinClkOut, pinClkOe, modeRd);
    end
    rst_n = 1'b1;
    curReq = "R1";  run(4);
    curReq = "R4";  run(60);
    curReq = "R2";  writeMode(6'h01); run(60);
    writeMode(6'h02); run(60);
    writeMode(6'h03); run(60);
    curReq = "R5";  writeMode(6'h20); run(60);
    writeMode(6'h21); run(60);
    curReq = "R6";  writeMode(6'h04); run(60);
    writeMode(6'h24); run(60);
    writeMode(6'h05); run(60);
    curReq = "R9";  writeMode(6'h08);
    for (int k = 0; k < 12; k++) begin
      xferActive = (k % 2) == 0;
      run(7 + 3 * k);
    end
    xferActive = 1'b0;
    writeMode(6'h29); run(20);
    xferActive = 1'b1; run(33);
    xferActive = 1'b0; run(21);
    curReq = "R3";  writeMode(6'h14); run(40);
    writeMode(6'h1C); run(40);
    writeMode(6'h0C); run(40);
    curReq = "R8";  writeMode(6'h06); run(40);
    writeMode(6'h0A); run(40);
    curReq = "R7";  writeMode(6'h04); run(10);
    wpLock = 1'b1;  writeMode(6'h21); run(40);
    writeMode(6'h02); run(20);
    wpLock = 1'b0;  writeMode(6'h21); run(40);
    curReq = "R10"; writeMode(6'h24); run(80);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
      $finish;
    end
  end

endmodule